// File: doc/BRIEF.md
# Double-Precision Round-to-Integral Unit

This unit accepts a 32-bit floating-point instruction word together with a 64-bit IEEE-754 double operand. It returns that operand rounded to an integral value, still in double format. The instruction word selects the rounding behaviour. A directed form carries a 2-bit mode field that picks ties-away, ties-to-even, ceiling or floor. A separate conditional form always truncates toward zero. The unit also reports the destination register index from the word, and it flags words it cannot execute, single-precision variants included.

The caller drives `in_valid` with the word and the operand for one cycle. On the next clock edge the unit registers the result, the destination index and the unrecognised flag, and raises `out_valid` for that one cycle. Condition-code evaluation, the register file and exception flags belong to the surrounding pipeline.

Top module: `rint_unit`

## Requirements
- R1: A word is a directed-form word when bits 31:28 = 1111, 27:23 = 11101, 21:20 = 11, 19:18 = 10, 11:9 = 101, 7:6 = 01 and bit 4 = 0. In that form, bits 17:16 select the rounding: 00 is nearest with ties away from zero, 01 is nearest with ties to even, 10 is toward +infinity, and 11 is toward -infinity.
- R2: A word is a truncate-form word, with any value in bits 31:28, when bits 27:23 = 11101, 21:20 = 11, 19:16 = 0110, 11:9 = 101, 7:6 = 11 and bit 4 = 0. It rounds toward zero.
- R3: The unit raises `bad_instr` and returns a result of all zeros in two cases: the word matches neither form, or bit 8 (size) is 0. It clears `bad_instr` for a supported word with bit 8 = 1.
- R4: `dest_idx` equals {bit 22, bits 15:12} of the accepted word.
- R5: Ties-away rounding gives -1 for -0.5, -1 for -0.6, -1 for -1.1, 1 for 0.5, 1 for 0.6, 1 for 1.1 and 3 for 2.5.
- R6: Ties-to-even rounding gives -0.0 for inputs in [-0.5, 0.0). It gives 0 for 0.5, 1 for 0.6, 2 for 2.5 and 4 for 3.5. For 2^52 - 0.5, the result is 2^52, with the exponent renormalised.
- R7: Ceiling gives -0.0 for -0.5 and -0.6, -1 for -1.1, 2 for 1.1 and 2 for 1.5. Floor gives -1 for -0.5, -2 for -1.1 and 0 for 0.6. Every zero result keeps the sign of the input.
- R8: Truncation gives -0.0 for -0.5 and -0.6, -1 for -1.1, and +0.0 for 0.5 and 0.6.
- R9: +infinity, -infinity and -0.0 pass through unchanged in every mode.
- R10: Any NaN input gives the canonical quiet NaN 0x7FF8000000000000.
- R11: An input whose unbiased exponent is 52 or more passes through unchanged.
- R12: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result, `dest_idx` and `bad_instr` appear with it. An active-low synchronous reset clears `out_valid`.
- R13: While `in_valid` is low, `result`, `dest_idx` and `bad_instr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word and operand are presented this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 64 | Double-precision source value |
| out_valid | output | 1 | Registered result is valid this cycle |
| result | output | 64 | Rounded double result |
| dest_idx | output | 5 | Destination register index |
| bad_instr | output | 1 | Word not recognised or not double-size |

## Verification
Every result is due exactly one rising edge after the cycle in which `in_valid` is sampled high, because a single register stage sits between the inputs and the outputs. The bench drives each request on a falling edge and drops `in_valid` on the next falling edge, so checks are sampled half a period after the registering edge, while `out_valid` must be high. The hold requirement is checked one idle cycle later, when `out_valid` must be low and the outputs unchanged.

// File: rtl/rint_pkg.sv
package rint_pkg;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int DBL_W   = 1 + EXP_W + FRAC_W;
    localparam int MAG_W   = EXP_W + FRAC_W;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;
    localparam int SHIFT_W = $clog2(FRAC_W + 1) + 1;
    localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] EXP_MAX  = {EXP_W{1'b1}};
    localparam logic [DBL_W-1:0] QNAN     = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        RM_AWAY  = 3'd0,
        RM_EVEN  = 3'd1,
        RM_CEIL  = 3'd2,
        RM_FLOOR = 3'd3,
        RM_TRUNC = 3'd4
    } rmode_e;

    typedef struct packed {
        logic             ok;
        rmode_e           mode;
        logic [IDX_W-1:0] dest;
    } dec_t;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [IDX_W-1:0] dest;
        logic [DBL_W-1:0] res;
    } out_t;
endpackage

// File: rtl/rint_decode.sv
module rint_decode
    import rint_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);
    logic common_ok;
    logic dir_hit;
    logic trz_hit;

    always_comb begin
        common_ok = (word[27:23] == 5'b11101) && (word[21:20] == 2'b11)
                 && (word[11:9] == 3'b101) && !word[4] && word[8];
        dir_hit   = common_ok && (word[31:28] == 4'hF) && (word[19:18] == 2'b10)
                 && (word[7:6] == 2'b01);
        trz_hit   = common_ok && (word[19:16] == 4'b0110) && (word[7:6] == 2'b11);

        dec.ok   = dir_hit || trz_hit;
        dec.dest = {word[22], word[15:12]};
        if (trz_hit) begin
            dec.mode = RM_TRUNC;
        end else begin
            dec.mode = rmode_e'({1'b0, word[17:16]});
        end
    end
endmodule

// File: rtl/rint_round.sv
module rint_round
    import rint_pkg::*;
(
    input  rmode_e           mode,
    input  logic [DBL_W-1:0] op,
    output logic [DBL_W-1:0] res
);
    logic               sgn;
    logic [EXP_W-1:0]   ex;
    logic [FRAC_W-1:0]  fr;
    logic [MAG_W-1:0]   mag;
    logic [EXP_W-1:0]   int_bits;
    logic [SHIFT_W-1:0] fb;
    logic [MAG_W-1:0]   unit;
    logic [MAG_W-1:0]   low_mask;
    logic [MAG_W-1:0]   half;
    logic               guard;
    logic               sticky;
    logic               lsb;
    logic               inexact;
    logic               bump;
    logic               small_up;
    logic [MAG_W-1:0]   cut;

    always_comb begin
        sgn      = op[DBL_W-1];
        ex       = op[DBL_W-2:FRAC_W];
        fr       = op[FRAC_W-1:0];
        mag      = op[MAG_W-1:0];
        int_bits = ex - EXP_BIAS;
        fb       = SHIFT_W'(FRAC_W) - SHIFT_W'(int_bits);
        unit     = MAG_W'(1) << fb;
        low_mask = unit - MAG_W'(1);
        half     = unit >> 1;
        guard    = |(mag & half);
        sticky   = |(mag & (low_mask >> 1));
        lsb      = (fb == SHIFT_W'(FRAC_W)) ? 1'b1 : |(mag & unit);
        inexact  = guard | sticky;
        cut      = mag & ~low_mask;

        unique case (mode)
            RM_AWAY:  bump = guard;
            RM_EVEN:  bump = guard & (sticky | lsb);
            RM_CEIL:  bump = !sgn & inexact;
            RM_FLOOR: bump = sgn & inexact;
            default:  bump = 1'b0;
        endcase

        unique case (mode)
            RM_AWAY:  small_up = (ex == EXP_BIAS - EXP_W'(1));
            RM_EVEN:  small_up = (ex == EXP_BIAS - EXP_W'(1)) && (fr != '0);
            RM_CEIL:  small_up = !sgn && (mag != '0);
            RM_FLOOR: small_up = sgn && (mag != '0);
            default:  small_up = 1'b0;
        endcase

        if (ex == EXP_MAX) begin
            res = (fr != '0) ? QNAN : op;
        end else if (ex >= EXP_BIAS + EXP_W'(FRAC_W)) begin
            res = op;
        end else if (ex < EXP_BIAS) begin
            res = small_up ? {sgn, EXP_BIAS, {FRAC_W{1'b0}}} : {sgn, {MAG_W{1'b0}}};
        end else begin
            // a carry out of the fraction lands in the exponent field
            res = {sgn, bump ? (cut + unit) : cut};
        end
    end
endmodule

// File: rtl/rint_unit.sv
module rint_unit
    import rint_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DBL_W-1:0]   operand,
    output logic               out_valid,
    output logic [DBL_W-1:0]   result,
    output logic [IDX_W-1:0]   dest_idx,
    output logic               bad_instr
);
    dec_t             dec;
    logic [DBL_W-1:0] rnd;
    out_t             st_d;
    out_t             st_q;

    rint_decode u_dec (
        .word (instr),
        .dec  (dec)
    );

    rint_round u_rnd (
        .mode (dec.mode),
        .op   (operand),
        .res  (rnd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.bad  = !dec.ok;
            st_d.dest = dec.dest;
            st_d.res  = dec.ok ? rnd : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign dest_idx  = st_q.dest;
    assign bad_instr = st_q.bad;

    // R12
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R13
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(dest_idx) && $stable(bad_instr)));

    // R3
    size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[8]) |=> (bad_instr && result == '0));

    // R10
    nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.ok && operand[DBL_W-2:FRAC_W] == EXP_MAX
         && operand[FRAC_W-1:0] != '0) |=> (result == QNAN));

    // R9
    inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.ok && operand[MAG_W-1:0] == {EXP_MAX, {FRAC_W{1'b0}}})
        |=> (result == $past(operand)));

    // R7
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.ok && operand[DBL_W-2:FRAC_W] != EXP_MAX)
        |=> (result[DBL_W-1] == $past(operand[DBL_W-1])));
endmodule

// File: tb/rint_unit_tb_top.sv
module rint_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] operand = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [4:0]  dest_idx;
    logic        bad_instr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PZ   = 64'h0;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;

    always #10 clk = ~clk;

    rint_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .operand   (operand),
        .out_valid (out_valid),
        .result    (result),
        .dest_idx  (dest_idx),
        .bad_instr (bad_instr)
    );

    function automatic logic [63:0] fx(input real r);
        return $realtobits(r);
    endfunction

    // directed word: mode 0 away, 1 even, 2 ceil, 3 floor
    function automatic logic [31:0] w_dir(input int mode, input logic [4:0] d);
        return 32'hFEB8_0B40 | (32'(mode) << 16) | (32'(d[4]) << 22) | (32'(d[3:0]) << 12);
    endfunction

    function automatic logic [31:0] w_trz(input logic [3:0] cnd, input logic [4:0] d);
        return 32'h0EB6_0BC0 | (32'(cnd) << 28) | (32'(d[4]) << 22) | (32'(d[3:0]) << 12);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [63:0] op);
        @(negedge clk);
        instr = w;
        operand = op;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic round_chk(input string req, input logic [31:0] w,
                             input logic [63:0] op, input logic [63:0] exp);
        issue(w, op);
        chk(req, {63'd0, out_valid}, 64'd1);
        chk(req, {63'd0, bad_instr}, 64'd0);
        chk(req, result, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_vectors;
        real ins [6] = '{-0.5, -0.6, -1.1, 0.5, 0.6, 1.1};
        logic [63:0] ea [6] = '{fx(-1.0), fx(-1.0), fx(-1.0), fx(1.0), fx(1.0), fx(1.0)};
        logic [63:0] en [6] = '{NZ, fx(-1.0), fx(-1.0), PZ, fx(1.0), fx(1.0)};
        logic [63:0] ef [6] = '{fx(-1.0), fx(-1.0), fx(-2.0), PZ, PZ, fx(1.0)};
        logic [63:0] ec [6] = '{NZ, NZ, fx(-1.0), fx(1.0), fx(1.0), fx(2.0)};
        logic [63:0] et [6] = '{NZ, NZ, fx(-1.0), PZ, PZ, fx(1.0)};
        for (int i = 0; i < 6; i++) begin
            round_chk("R5 ties-away", w_dir(0, 5'd1), fx(ins[i]), ea[i]);
            round_chk("R6 ties-even", w_dir(1, 5'd1), fx(ins[i]), en[i]);
            round_chk("R7 ceiling", w_dir(2, 5'd1), fx(ins[i]), ec[i]);
            round_chk("R7 floor", w_dir(3, 5'd1), fx(ins[i]), ef[i]);
            round_chk("R8 truncate", w_trz(4'hE, 5'd1), fx(ins[i]), et[i]);
        end
    endtask

    task automatic t_ties;
        round_chk("R5 away 2.5", w_dir(0, 5'd0), fx(2.5), fx(3.0));
        round_chk("R6 even 2.5", w_dir(1, 5'd0), fx(2.5), fx(2.0));
        round_chk("R6 even 3.5", w_dir(1, 5'd0), fx(3.5), fx(4.0));
        round_chk("R6 even -0.25", w_dir(1, 5'd0), fx(-0.25), NZ);
        round_chk("R6 even renorm", w_dir(1, 5'd0), 64'h432F_FFFF_FFFF_FFFF, 64'h4330_0000_0000_0000);
        round_chk("R7 ceil 1.5 carry", w_dir(2, 5'd0), fx(1.5), fx(2.0));
        round_chk("R11 large pass", w_dir(3, 5'd0), 64'h4340_0000_0000_0001, 64'h4340_0000_0000_0001);
        round_chk("R11 exp52 pass", w_dir(2, 5'd0), 64'hC330_0000_0000_0001, 64'hC330_0000_0000_0001);
    endtask

    task automatic t_special;
        for (int m = 0; m < 5; m++) begin
            logic [31:0] w;
            w = (m < 4) ? w_dir(m, 5'd3) : w_trz(4'h0, 5'd3);
            round_chk("R9 +inf", w, PINF, PINF);
            round_chk("R9 -inf", w, NINF, NINF);
            round_chk("R9 -0", w, NZ, NZ);
            round_chk("R10 qnan", w, 64'h7FF8_0000_0000_1234, QNAN);
            round_chk("R10 snan neg", w, 64'hFFF0_0000_0000_0001, QNAN);
        end
    endtask

    task automatic t_decode;
        issue(32'hFEB8_2B43, fx(0.5));
        chk("R1 example word result", result, fx(1.0));
        chk("R4 dest example", {59'd0, dest_idx}, 64'd2);
        issue(32'h1EB6_2BC3, fx(-1.7));
        chk("R2 cond 0001 truncate", result, fx(-1.0));
        chk("R2 cond 0001 ok", {63'd0, bad_instr}, 64'd0);
        issue(w_dir(2, 5'd22), fx(0.1));
        chk("R4 dest high bit", {59'd0, dest_idx}, 64'd22);
        chk("R1 mode 10 ceiling", result, fx(1.0));
        issue(w_dir(0, 5'd1) & ~32'h0000_0100, fx(1.5));
        chk("R3 size0 flagged", {63'd0, bad_instr}, 64'd1);
        chk("R3 size0 result zero", result, 64'd0);
        issue(w_trz(4'hE, 5'd1) & ~32'h0000_0100, fx(1.5));
        chk("R3 trunc size0 flagged", {63'd0, bad_instr}, 64'd1);
        issue(w_dir(0, 5'd1) & ~32'hF000_0000 | 32'hE000_0000, fx(1.5));
        chk("R3 directed bad cond", {63'd0, bad_instr}, 64'd1);
        issue(w_dir(0, 5'd1) | 32'h0000_0010, fx(1.5));
        chk("R3 bit4 set", {63'd0, bad_instr}, 64'd1);
        issue(w_trz(4'hE, 5'd1) ^ 32'h0001_0000, fx(1.5));
        chk("R3 trunc bit16 set", {63'd0, bad_instr}, 64'd1);
    endtask

    task automatic t_latency_hold;
        logic [63:0] kept;
        issue(w_dir(3, 5'd9), fx(-2.5));
        chk("R12 valid one cycle after", {63'd0, out_valid}, 64'd1);
        kept = result;
        chk("R7 floor -2.5", kept, fx(-3.0));
        instr = w_dir(0, 5'd4);
        operand = fx(7.5);
        @(negedge clk);
        chk("R12 valid drops", {63'd0, out_valid}, 64'd0);
        chk("R13 result held", result, kept);
        chk("R13 dest held", {59'd0, dest_idx}, 64'd9);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        chk("R12 reset clears valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_vectors();
        t_ties();
        t_special();
        t_decode();
        t_latency_hold();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            report();
        end
    end
endmodule